// File: doc/BRIEF.md
# Priority-Preemptive Vectored Interrupt Controller

This block gathers interrupt requests from level-sensitive hardware lines and from a bank of software-triggerable sources. Each source carries a 4-bit priority held in the block. Every cycle the block picks the highest-priority pending source. That choice is offered to the processor only when its priority is strictly above the current task priority. The offer carries a 9-bit vector that names the source. When two sources share a priority, the one with the lower index wins.

The current priority is a register the processor can write directly. This lets it run a priority-ceiling protocol around shared resources. Acknowledging an offered interrupt saves the old current priority on an internal stack and raises the current priority to that of the acknowledged source. An end-of-interrupt pulse restores the saved value. Software sources occupy indices 0 to N_SW-1 and hardware sources follow them, so with the default parameters hardware line k is source N_SW+k.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, no software source is pending, every source priority is 0, the current priority is 0, the save stack is empty and irq_req is low.
- R2: A cycle with prio_we high stores prio_wdata as the priority of source prio_idx from the next cycle on. A source whose priority is 0 never wins and never raises a request.
- R3: For software source i (indices 0 to N_SW-1), sw_set[i] makes it pending from the next cycle and sw_clr[i] clears it. If both are high in the same cycle, clear wins. Acknowledging a software source does not clear it.
- R4: Hardware line k is source N_SW+k. It is pending exactly while hw_irq[k] is high, and it affects irq_req and irq_vec in the same cycle with no register in between.
- R5: irq_req is high exactly when the highest priority among pending sources is strictly greater than cur_prio. A source whose priority equals cur_prio is blocked.
- R6: Among pending sources with the highest priority, the lowest index wins. While irq_req is high, irq_vec equals that index, zero-extended to 9 bits.
- R7: A cycle with ack and irq_req both high pushes cur_prio onto the stack and loads the winner's priority into cur_prio for the next cycle. ack while irq_req is low changes nothing.
- R8: An eoi pulse pops the stack into cur_prio. eoi with an empty stack leaves cur_prio unchanged. When an ack takes effect in the same cycle, the eoi is ignored.
- R9: mask_we loads mask_wdata into cur_prio for the next cycle and leaves the stack alone. It has no effect in a cycle where a push or a pop takes place.
- R10: The stack holds DEPTH (16) entries. An ack that arrives while the stack is full has no effect, and the interrupt stays offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | N_HW | Level-sensitive hardware request lines |
| sw_set | input | N_SW | Set pulses for the software sources |
| sw_clr | input | N_SW | Clear pulses for the software sources |
| prio_we | input | 1 | Priority write strobe |
| prio_idx | input | IDX_W | Source selected by the priority write |
| prio_wdata | input | 4 | Priority value to store |
| mask_we | input | 1 | Current-priority write strobe |
| mask_wdata | input | 4 | New current priority |
| ack | input | 1 | Processor acknowledge of the offered interrupt |
| eoi | input | 1 | End-of-interrupt pulse |
| irq_req | output | 1 | Interrupt offered to the processor |
| irq_vec | output | 9 | Vector of the offered source |
| cur_prio | output | 4 | Current task priority |

## Verification
The assertions assume that ack, eoi and mask_we are single-cycle pulses sampled at the clock edge. They also assume hw_irq is synchronous to clk, so the same-cycle path from a hardware line to irq_req settles before the edge. The bench drives every input one time unit after the rising edge and samples outputs on the falling edge. It only raises ack in cycles where the reference model shows an interrupt on offer, except for the deliberate stray ack that checks it is ignored. The full-stack case lowers the current priority between acknowledges so that sixteen real pushes happen and the seventeenth is refused.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 9;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank import irq_pkg::*; #(
  parameter int N_SW = 8,
  parameter int N_HW = 8,
  localparam int N_SRC = N_SW + N_HW,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_HW-1:0]        hw_irq,
  input  logic [N_SW-1:0]        sw_set,
  input  logic [N_SW-1:0]        sw_clr,
  input  logic                   prio_we,
  input  logic [IDX_W-1:0]       prio_idx,
  input  prio_t                  prio_wdata,
  output logic [N_SW-1:0]        sw_pend,
  output logic [N_SRC-1:0]       pend,
  output prio_t [N_SRC-1:0]      prio
);
  logic [N_SW-1:0] sw_pend_nxt;
  logic            sw_pend_en;

  always_comb begin
    sw_pend_nxt = (sw_pend | sw_set) & ~sw_clr;
    sw_pend_en  = |(sw_set | sw_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sw_pend <= '0;
    else if (sw_pend_en) sw_pend <= sw_pend_nxt;
  end

  assign pend = {hw_irq, sw_pend};

  for (genvar g = 0; g < N_SRC; g++) begin : g_prio
    logic sel;
    assign sel = prio_we && (prio_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prio[g] <= '0;
      else if (sel) prio[g] <= prio_wdata;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter import irq_pkg::*; #(
  parameter int N_SRC = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]  pend,
  input  prio_t [N_SRC-1:0] prio,
  output prio_t             win_prio,
  output logic [IDX_W-1:0]  win_idx
);
  always_comb begin
    win_prio = '0;
    win_idx  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i] && (prio[i] > win_prio)) begin
        win_prio = prio[i];
        win_idx  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack import irq_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_req,
  input  logic            eoi,
  input  logic            mask_we,
  input  prio_t           mask_wdata,
  input  prio_t           win_prio,
  output prio_t           cur_prio,
  output logic [SP_W-1:0] depth
);
  localparam logic [SP_W-1:0] FULL = SP_W'(DEPTH);

  prio_t           stk [DEPTH];
  logic            do_push, do_pop, do_mask, cur_en, depth_en;
  prio_t           cur_nxt;
  logic [SP_W-1:0] depth_nxt, top;

  always_comb begin
    top       = depth - SP_W'(1);
    do_push   = push_req && (depth != FULL);
    do_pop    = eoi && !do_push && (depth != '0);
    do_mask   = mask_we && !do_push && !do_pop;
    cur_en    = do_push || do_pop || do_mask;
    depth_en  = do_push || do_pop;
    if (do_push)     cur_nxt = win_prio;
    else if (do_pop) cur_nxt = stk[top[PTR_W-1:0]];
    else             cur_nxt = mask_wdata;
    depth_nxt = do_push ? depth + SP_W'(1) : top;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_prio <= '0;
      depth    <= '0;
    end else begin
      if (cur_en)   cur_prio <= cur_nxt;
      if (depth_en) depth    <= depth_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) stk[depth[PTR_W-1:0]] <= cur_prio;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl import irq_pkg::*; #(
  parameter int N_SW  = 8,
  parameter int N_HW  = 8,
  parameter int DEPTH = 16,
  localparam int N_SRC = N_SW + N_HW,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_HW-1:0]   hw_irq,
  input  logic [N_SW-1:0]   sw_set,
  input  logic [N_SW-1:0]   sw_clr,
  input  logic              prio_we,
  input  logic [IDX_W-1:0]  prio_idx,
  input  logic [PRIO_W-1:0] prio_wdata,
  input  logic              mask_we,
  input  logic [PRIO_W-1:0] mask_wdata,
  input  logic              ack,
  input  logic              eoi,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [PRIO_W-1:0] cur_prio
);
  logic [N_SW-1:0]   sw_pend;
  logic [N_SRC-1:0]  pend;
  prio_t [N_SRC-1:0] prio;
  prio_t             win_prio;
  logic [IDX_W-1:0]  win_idx;
  logic [SP_W-1:0]   depth;

  irq_src_bank #(.N_SW(N_SW), .N_HW(N_HW)) bank_i (
    .clk, .rst_n, .hw_irq, .sw_set, .sw_clr, .prio_we, .prio_idx,
    .prio_wdata, .sw_pend, .pend, .prio
  );

  irq_arbiter #(.N_SRC(N_SRC)) arb_i (
    .pend, .prio, .win_prio, .win_idx
  );

  assign irq_req = (win_prio > cur_prio);
  assign irq_vec = VEC_W'(win_idx);

  irq_prio_stack #(.DEPTH(DEPTH)) stack_i (
    .clk, .rst_n, .push_req(ack && irq_req), .eoi, .mask_we, .mask_wdata,
    .win_prio, .cur_prio, .depth
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk import irq_pkg::*; #(
  parameter int N_SW  = 8,
  parameter int N_SRC = 16,
  parameter int DEPTH = 16,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic              eoi,
  input logic              mask_we,
  input logic              irq_req,
  input logic [VEC_W-1:0]  irq_vec,
  input logic [PRIO_W-1:0] cur_prio,
  input logic [PRIO_W-1:0] win_prio,
  input logic [SP_W-1:0]   depth,
  input logic [N_SW-1:0]   sw_clr,
  input logic [N_SW-1:0]   sw_pend
);
  localparam logic [SP_W-1:0]  FULL = SP_W'(DEPTH);
  localparam logic [VEC_W-1:0] NVEC = VEC_W'(N_SRC);

  a_r7_push_loads_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && depth != FULL) |=> (cur_prio == $past(win_prio)));

  a_r7_push_grows_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && depth != FULL) |=> (depth == $past(depth) + SP_W'(1)));

  a_r10_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && depth == FULL && !eoi && !mask_we) |=> (depth == FULL && $stable(cur_prio)));

  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= FULL);

  a_r8_empty_eoi_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && !mask_we && depth == '0) |=> $stable(cur_prio));

  a_r8_pop_shrinks_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && depth != '0) |=> (depth == $past(depth) - SP_W'(1)));

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_clr) |=> ((sw_pend & $past(sw_clr)) == '0));

  a_r6_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec < NVEC));

  a_r2_zero_never_requests: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (win_prio != '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SW(N_SW), .N_SRC(N_SRC), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack(ack), .eoi(eoi), .mask_we(mask_we),
  .irq_req(irq_req), .irq_vec(irq_vec), .cur_prio(cur_prio),
  .win_prio(win_prio), .depth(depth), .sw_clr(sw_clr), .sw_pend(sw_pend)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_SW = 8;
  localparam int N_HW = 8;
  localparam int N_SRC = N_SW + N_HW;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_HW-1:0] hw_irq = '0;
  logic [N_SW-1:0] sw_set = '0, sw_clr = '0;
  logic prio_we = 1'b0;
  logic [3:0] prio_idx = '0;
  logic [3:0] prio_wdata = '0;
  logic mask_we = 1'b0;
  logic [3:0] mask_wdata = '0;
  logic ack = 1'b0, eoi = 1'b0;
  logic irq_req;
  logic [8:0] irq_vec;
  logic [3:0] cur_prio;

  int checks = 0, fails = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl #(.N_SW(N_SW), .N_HW(N_HW), .DEPTH(DEPTH)) dut_i (
    .clk, .rst_n, .hw_irq, .sw_set, .sw_clr, .prio_we, .prio_idx, .prio_wdata,
    .mask_we, .mask_wdata, .ack, .eoi, .irq_req, .irq_vec, .cur_prio
  );

  // Behavioural reference model
  bit m_pend [N_SW];
  int m_prio [N_SRC];
  int m_cur;
  int m_stk [$];

  function automatic void model_best(output int bp, output int bi);
    bp = 0; bi = 0;
    for (int i = 0; i < N_SRC; i++) begin
      bit p = (i < N_SW) ? m_pend[i] : hw_irq[i-N_SW];
      if (p && m_prio[i] > bp) begin bp = m_prio[i]; bi = i; end
    end
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N_SW; i++) m_pend[i] = 0;
    for (int i = 0; i < N_SRC; i++) m_prio[i] = 0;
    m_cur = 0;
    m_stk.delete();
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int bp, bi;
      bit pushed, popped;
      model_best(bp, bi);
      pushed = ack && (bp > m_cur) && (m_stk.size() < DEPTH);
      popped = !pushed && eoi && (m_stk.size() > 0);
      if (pushed) begin m_stk.push_back(m_cur); m_cur = bp; end
      else if (popped) m_cur = m_stk.pop_back();
      else if (mask_we) m_cur = int'(mask_wdata);
      for (int i = 0; i < N_SW; i++)
        if (sw_clr[i]) m_pend[i] = 0; else if (sw_set[i]) m_pend[i] = 1;
      if (prio_we) m_prio[prio_idx] = int'(prio_wdata);
    end
  end

  task automatic chk(string t, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      int bp, bi;
      model_best(bp, bi);
      chk(tag, int'(irq_req), int'(bp > m_cur), "irq_req");
      if (bp > m_cur) chk(tag, int'(irq_vec), bi, "irq_vec");
      chk(tag, int'(cur_prio), m_cur, "cur_prio");
    end
  end

  task automatic step();
    @(posedge clk); #1;
    sw_set = '0; sw_clr = '0; prio_we = 0; mask_we = 0; ack = 0; eoi = 0;
  endtask

  task automatic set_prio(int idx, int p);
    prio_we = 1; prio_idx = 4'(idx); prio_wdata = 4'(p); step();
  endtask

  task automatic expect_out(string t, int req, int vec, int cur);
    @(negedge clk);
    chk(t, int'(irq_req), req, "direct irq_req");
    if (req != 0) chk(t, int'(irq_vec), vec, "direct irq_vec");
    chk(t, int'(cur_prio), cur, "direct cur_prio");
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: idle after reset
    tag = "R1"; expect_out("R1", 0, 0, 0);

    // R2: priority 0 disables a pending source
    tag = "R2";
    sw_set = 8'h01; step();
    expect_out("R2", 0, 0, 0);
    set_prio(0, 3);
    expect_out("R2", 1, 0, 0);

    // R3: clear, and set+clear in one cycle
    tag = "R3";
    sw_clr = 8'h01; step();
    expect_out("R3", 0, 0, 0);
    set_prio(4, 9);
    sw_set = 8'h10; sw_clr = 8'h10; step();
    expect_out("R3", 0, 0, 0);

    // R4: hardware line 2 -> source 10, same-cycle
    tag = "R4";
    set_prio(10, 7);
    @(negedge clk); hw_irq = 8'h04; #1;
    checks++;
    if (!(irq_req === 1'b1 && irq_vec == 9'd10)) begin
      fails++; $display("FAIL R4 same-cycle actual=%0b/%0d expected=1/10", irq_req, irq_vec);
    end
    hw_irq = '0; #1;
    checks++;
    if (irq_req !== 1'b0) begin
      fails++; $display("FAIL R4 drop actual=%0b expected=0", irq_req);
    end
    step();

    // R6: tie at priority 6, lowest index wins
    tag = "R6";
    set_prio(2, 6); set_prio(5, 6);
    sw_set = 8'h24; step();
    expect_out("R6", 1, 2, 0);
    hw_irq = 8'h01; set_prio(8, 6); // source 8 also 6, index 2 still wins
    expect_out("R6", 1, 2, 0);
    hw_irq = '0;

    // R5: mask equal blocks, below allows
    tag = "R5";
    mask_we = 1; mask_wdata = 4'd6; step();
    expect_out("R5", 0, 0, 6);
    mask_we = 1; mask_wdata = 4'd5; step();
    expect_out("R5", 1, 2, 5);

    // R7: acknowledge pushes and raises; source stays pending (R3)
    tag = "R7";
    ack = 1; step();
    expect_out("R7", 0, 0, 6);
    ack = 1; step();              // stray ack while no request
    expect_out("R7", 0, 0, 6);
    hw_irq = 8'h02; set_prio(9, 12);
    expect_out("R7", 1, 9, 6);
    ack = 1; step();
    expect_out("R7", 0, 0, 12);

    // R8: pops restore, ack beats eoi
    tag = "R8";
    eoi = 1; step();
    expect_out("R8", 1, 9, 6);
    ack = 1; eoi = 1; step();
    expect_out("R8", 0, 0, 12);
    hw_irq = '0;
    eoi = 1; step(); eoi = 1; step(); eoi = 1; step();
    expect_out("R8", 1, 2, 5);
    eoi = 1; step();              // empty stack
    expect_out("R8", 1, 2, 5);

    // R9: mask write alone, and mask write losing to a pop
    tag = "R9";
    ack = 1; step();              // push 5, cur 6
    mask_we = 1; mask_wdata = 4'd1; eoi = 1; step();
    expect_out("R9", 1, 2, 5);
    mask_we = 1; mask_wdata = 4'd0; step();
    expect_out("R9", 1, 2, 0);

    // R10: fill the stack, refuse the extra ack
    tag = "R10";
    sw_clr = 8'hFF; step();
    set_prio(1, 5); sw_set = 8'h02; step();
    for (int k = 0; k < DEPTH + 1; k++) begin
      mask_we = 1; mask_wdata = 4'd0; step();
      ack = 1; step();
    end
    expect_out("R10", 1, 1, 0);
    for (int k = 0; k < DEPTH; k++) begin eoi = 1; step(); end
    expect_out("R10", 1, 1, 0);
    ack = 1; step();
    expect_out("R10", 0, 0, 5);

    repeat (2) step();
    finish_run();
  end
endmodule